// File: doc/BRIEF.md
# Drive-Side Link Speed Negotiator

This block brings up the serial link toward one downstream drive and settles the line rate. It drives out-of-band request pulses (reset, calibrate, wake) into an abstracted PHY and consumes the out-of-band detector strobes coming back. After the drive answers the reset request and the wake exchange, the block holds a continuous D10.2 filler pattern. It watches for the drive's first ALIGN primitive and takes the drive's generation from the rate at which that ALIGN was recognised. It then transmits ALIGN at that same rate, and once that phase ends it declares the link up.

Each port negotiates on its own. A configuration input can ask for a speed shared with the host side. When it is set and the host rate mask names at least one rate, ALIGNs at rates outside that mask are ignored. The drive then falls back to a lower rate, and the block accepts that rate instead. Programmable cycle limits bound the waits for the reset answer, the wake answer and the first ALIGN. Any expiry restarts the reset handshake.

Top module: `drv_link_negotiator`

## Requirements
- R1: While reset is asserted or `port_en` is low, the block is in state RESET (code 0) on the next clock. In that state `link_up`, `rate_sel`, `tx_pat` and all three request pulses are 0.
- R2: On entering AWAIT_COMINIT (code 1), `comreset_req` is high for exactly one cycle. A `cominit_det` strobe there moves the block to CALIBRATE (code 2), and `calibrate_req` is high for exactly one cycle.
- R3: If no `cominit_det` arrives within INIT_TMO cycles of entering AWAIT_COMINIT, the block goes to RESET for one cycle and then reissues `comreset_req`.
- R4: CALIBRATE lasts CAL_CYCLES cycles. It then moves to AWAIT_COMWAKE (code 3) with a one-cycle `comwake_req`. If no `comwake_det` arrives there within WAKE_TMO cycles, the block returns to RESET.
- R5: A `comwake_det` in AWAIT_COMWAKE moves the block to SEND_D10_2 (code 4). `tx_pat` encodes 0 as idle, 1 as D10.2 filler, 2 as ALIGN and 3 as link traffic. SEND_D10_2 drives 1 until an accepted ALIGN arrives.
- R6: An accepted ALIGN strobe on `align_det` (bit 0 = 1.5 Gb/s, bit 1 = 3.0 Gb/s) moves the block to SEND_ALIGN (code 5). It sets `rate_sel` to the index of the accepted rate, choosing the higher rate when both strobes arrive together, and drives `tx_pat`=2 for ALIGN_TX cycles before READY (code 6).
- R7: If no accepted ALIGN arrives within ALIGN_TMO cycles of entering SEND_D10_2, the block returns to RESET.
- R8: With `common_req` high and `host_mask` nonzero, only ALIGN strobes on bits set in `host_mask` are accepted. Others leave the state and `rate_sel` unchanged. With `host_mask` zero or `common_req` low, all rates are accepted.
- R9: `link_up` is high exactly while the state is READY. In READY, `tx_pat` is 3 and `rate_sel` holds the negotiated rate.
- R10: In READY, a `los` or `cominit_det` strobe returns the block to RESET on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; low holds RESET |
| common_req | input | 1 | Request a speed shared with the host side |
| host_mask | input | NUM_GEN | Rates the host side supports, bit g = generation g+1 |
| los | input | 1 | Loss-of-signal strobe |
| cominit_det | input | 1 | Reset-answer out-of-band strobe from the drive |
| comwake_det | input | 1 | Wake out-of-band strobe from the drive |
| align_det | input | NUM_GEN | ALIGN-received strobe, one bit per rate |
| comreset_req | output | 1 | One-cycle reset out-of-band request to the PHY |
| calibrate_req | output | 1 | One-cycle calibrate request to the PHY |
| comwake_req | output | 1 | One-cycle wake out-of-band request to the PHY |
| tx_pat | output | 2 | Transmit pattern select |
| rate_sel | output | GW | Line-rate select, index of the generation |
| link_up | output | 1 | Link negotiated and ready |
| state_o | output | 3 | Encoded negotiation state |

## Verification
The hardest case to reach is shared-speed mode. There a faster ALIGN must be refused while the filler keeps going, and a slower ALIGN that follows must still be taken. The stimulus reaches it by walking the full handshake with a host mask that excludes the faster rate. It strobes the faster ALIGN first and then the slower one, checking the state and rate after each. Each timeout is driven by holding the answer back and counting cycles from state entry, so the cycle of the restart is checked exactly. Simultaneous strobes at both rates and a mask of zero are covered the same way.

// File: rtl/lnk_neg_pkg.sv
// Shared types for the drive-side link speed negotiator.
// Assumes state codes are visible at the top ports and are fixed.
package lnk_neg_pkg;

    typedef enum logic [2:0] {
        LS_RESET     = 3'd0,
        LS_WAIT_INIT = 3'd1,
        LS_CAL       = 3'd2,
        LS_WAIT_WAKE = 3'd3,
        LS_FILL      = 3'd4,
        LS_ALIGN     = 3'd5,
        LS_READY     = 3'd6
    } lnk_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_FILL  = 2'd1,
        TX_ALIGN = 2'd2,
        TX_PASS  = 2'd3
    } tx_pat_e;

endpackage

// File: rtl/lnk_timer.sv
// Phase timer: counts cycles since the last clear and flags when the
// count reaches limit-1, so a phase lasts exactly 'limit' cycles.
// Assumes limit >= 1. The counter stops at expiry until the next clear.
module lnk_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == (limit - CNT_W'(1)));

    // Count cycles in the current phase, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lnk_rate_pick.sv
// Rate acceptance: masks the per-rate ALIGN strobes with the set of
// allowed rates and picks the highest accepted one.
// Assumes bit g of align_det and host_mask stands for generation g+1.
module lnk_rate_pick #(
    parameter int unsigned NUM_GEN = 2,
    parameter int unsigned GW      = 1
) (
    input  logic [NUM_GEN-1:0] align_det,
    input  logic               common_req,
    input  logic [NUM_GEN-1:0] host_mask,
    output logic               hit,
    output logic [GW-1:0]      pick
);

    logic               use_mask;
    logic [NUM_GEN-1:0] allowed;
    logic [NUM_GEN-1:0] hits;

    assign use_mask = common_req && (host_mask != '0);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_allow
        assign allowed[g] = use_mask ? host_mask[g] : 1'b1;
        assign hits[g]    = align_det[g] & allowed[g];
    end

    assign hit = |hits;

    // Highest accepted rate wins.
    always_comb begin
        pick = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (hits[g]) begin
                pick = GW'(g);
            end
        end
    end

endmodule

// File: rtl/lnk_seq_fsm.sv
// Negotiation sequencer: walks reset handshake, calibrate, wake,
// filler, ALIGN echo and ready; emits one-cycle OOB requests on entry
// to the phases that need them and latches the accepted rate.
// Assumes event strobes are single-cycle and synchronous to clk.
module lnk_seq_fsm
    import lnk_neg_pkg::*;
#(
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned GW         = 1,
    parameter int unsigned INIT_TMO   = 1000000,
    parameter int unsigned CAL_CYCLES = 64,
    parameter int unsigned WAKE_TMO   = 1000000,
    parameter int unsigned ALIGN_TMO  = 1000000,
    parameter int unsigned ALIGN_TX   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             los,
    input  logic             cominit_det,
    input  logic             comwake_det,
    input  logic             align_hit,
    input  logic [GW-1:0]    align_pick,
    input  logic             tmr_expired,
    output logic             tmr_clr,
    output logic [CNT_W-1:0] tmr_limit,
    output logic [2:0]       state_o,
    output logic [1:0]       tx_pat,
    output logic             comreset_req,
    output logic             calibrate_req,
    output logic             comwake_req,
    output logic [GW-1:0]    rate_sel,
    output logic             link_up
);

    lnk_state_e    state_q, state_d;
    logic          comreset_q, cal_q, wake_q, link_q;
    logic [GW-1:0] rate_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!port_en) begin
            state_d = LS_RESET;
        end else begin
            case (state_q)
                LS_RESET:     state_d = LS_WAIT_INIT;
                LS_WAIT_INIT: begin
                    if (cominit_det)      state_d = LS_CAL;
                    else if (tmr_expired) state_d = LS_RESET;
                end
                LS_CAL: begin
                    if (tmr_expired)      state_d = LS_WAIT_WAKE;
                end
                LS_WAIT_WAKE: begin
                    if (comwake_det)      state_d = LS_FILL;
                    else if (tmr_expired) state_d = LS_RESET;
                end
                LS_FILL: begin
                    if (align_hit)        state_d = LS_ALIGN;
                    else if (tmr_expired) state_d = LS_RESET;
                end
                LS_ALIGN: begin
                    if (tmr_expired)      state_d = LS_READY;
                end
                LS_READY: begin
                    if (los || cominit_det) state_d = LS_RESET;
                end
                default:                  state_d = LS_RESET;
            endcase
        end
    end

    // Phase limit for the timer, chosen by the current state.
    always_comb begin
        case (state_q)
            LS_WAIT_INIT: tmr_limit = CNT_W'(INIT_TMO);
            LS_CAL:       tmr_limit = CNT_W'(CAL_CYCLES);
            LS_WAIT_WAKE: tmr_limit = CNT_W'(WAKE_TMO);
            LS_FILL:      tmr_limit = CNT_W'(ALIGN_TMO);
            LS_ALIGN:     tmr_limit = CNT_W'(ALIGN_TX);
            default:      tmr_limit = CNT_W'(1);
        endcase
    end

    assign tmr_clr = (state_d != state_q);

    // Transmit pattern follows the current state.
    always_comb begin
        case (state_q)
            LS_FILL:  tx_pat = TX_FILL;
            LS_ALIGN: tx_pat = TX_ALIGN;
            LS_READY: tx_pat = TX_PASS;
            default:  tx_pat = TX_IDLE;
        endcase
    end

    // State register and entry pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LS_RESET;
            comreset_q <= 1'b0;
            cal_q      <= 1'b0;
            wake_q     <= 1'b0;
            link_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            comreset_q <= (state_d == LS_WAIT_INIT) && (state_q != LS_WAIT_INIT);
            cal_q      <= (state_d == LS_CAL) && (state_q != LS_CAL);
            wake_q     <= (state_d == LS_WAIT_WAKE) && (state_q != LS_WAIT_WAKE);
            link_q     <= (state_d == LS_READY);
        end
    end

    // Line-rate latch: captured when an ALIGN is accepted, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (state_d == LS_RESET) begin
            rate_q <= '0;
        end else if ((state_q == LS_FILL) && (state_d == LS_ALIGN)) begin
            rate_q <= align_pick;
        end
    end

    assign state_o       = state_q;
    assign comreset_req  = comreset_q;
    assign calibrate_req = cal_q;
    assign comwake_req   = wake_q;
    assign rate_sel      = rate_q;
    assign link_up       = link_q;

endmodule

// File: rtl/drv_link_negotiator.sv
// Top of the drive-side link speed negotiator: connects the rate
// acceptance logic, the sequencer and the shared phase timer.
// Assumes all inputs are synchronous to clk; OOB detection lives in the PHY.
module drv_link_negotiator #(
    parameter int unsigned NUM_GEN    = 2,
    parameter int unsigned GW         = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned INIT_TMO   = 1000000,
    parameter int unsigned CAL_CYCLES = 64,
    parameter int unsigned WAKE_TMO   = 1000000,
    parameter int unsigned ALIGN_TMO  = 1000000,
    parameter int unsigned ALIGN_TX   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               common_req,
    input  logic [NUM_GEN-1:0] host_mask,
    input  logic               los,
    input  logic               cominit_det,
    input  logic               comwake_det,
    input  logic [NUM_GEN-1:0] align_det,
    output logic               comreset_req,
    output logic               calibrate_req,
    output logic               comwake_req,
    output logic [1:0]         tx_pat,
    output logic [GW-1:0]      rate_sel,
    output logic               link_up,
    output logic [2:0]         state_o
);

    logic             align_hit;
    logic [GW-1:0]    align_pick;
    logic             tmr_expired;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_limit;

    lnk_rate_pick #(
        .NUM_GEN (NUM_GEN),
        .GW      (GW)
    ) u_pick (
        .align_det  (align_det),
        .common_req (common_req),
        .host_mask  (host_mask),
        .hit        (align_hit),
        .pick       (align_pick)
    );

    lnk_seq_fsm #(
        .CNT_W      (CNT_W),
        .GW         (GW),
        .INIT_TMO   (INIT_TMO),
        .CAL_CYCLES (CAL_CYCLES),
        .WAKE_TMO   (WAKE_TMO),
        .ALIGN_TMO  (ALIGN_TMO),
        .ALIGN_TX   (ALIGN_TX)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_en       (port_en),
        .los           (los),
        .cominit_det   (cominit_det),
        .comwake_det   (comwake_det),
        .align_hit     (align_hit),
        .align_pick    (align_pick),
        .tmr_expired   (tmr_expired),
        .tmr_clr       (tmr_clr),
        .tmr_limit     (tmr_limit),
        .state_o       (state_o),
        .tx_pat        (tx_pat),
        .comreset_req  (comreset_req),
        .calibrate_req (calibrate_req),
        .comwake_req   (comwake_req),
        .rate_sel      (rate_sel),
        .link_up       (link_up)
    );

    lnk_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

endmodule

// File: rtl/lnk_neg_checker.sv
// Protocol checker for the negotiator, observing top-level ports only.
// Assumes the state encoding of lnk_neg_pkg.
module lnk_neg_checker
    import lnk_neg_pkg::*;
#(
    parameter int unsigned NUM_GEN = 2,
    parameter int unsigned GW      = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               port_en,
    input logic               common_req,
    input logic [NUM_GEN-1:0] host_mask,
    input logic               los,
    input logic               cominit_det,
    input logic               comreset_req,
    input logic [GW-1:0]      rate_sel,
    input logic               link_up,
    input logic [2:0]         state_o
);

    logic [NUM_GEN-1:0] mask_prev;
    logic               common_prev;
    logic [2:0]         state_prev;

    // Previous-cycle copies of the configuration and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_prev   <= '0;
            common_prev <= 1'b0;
            state_prev  <= LS_RESET;
        end else begin
            mask_prev   <= host_mask;
            common_prev <= common_req;
            state_prev  <= state_o;
        end
    end

    AST_DISABLE_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (state_o == LS_RESET)); // R1

    AST_COMRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        comreset_req |=> !comreset_req); // R2

    AST_COMRESET_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        comreset_req |-> (state_o == LS_WAIT_INIT)); // R2

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == LS_ALIGN) && port_en) |=> $stable(rate_sel)); // R6

    AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == LS_ALIGN) && (state_prev == LS_FILL) && common_prev
         && (mask_prev != '0)) |-> mask_prev[rate_sel]); // R8

    AST_UP_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (state_o == LS_READY)); // R9

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == LS_READY) && (los || cominit_det)) |=> (state_o == LS_RESET)); // R10

endmodule

bind drv_link_negotiator lnk_neg_checker #(
    .NUM_GEN (NUM_GEN),
    .GW      (GW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .common_req   (common_req),
    .host_mask    (host_mask),
    .los          (los),
    .cominit_det  (cominit_det),
    .comreset_req (comreset_req),
    .rate_sel     (rate_sel),
    .link_up      (link_up),
    .state_o      (state_o)
);

// File: tb/drv_link_negotiator_test.sv
`timescale 1ns/1ps
module drv_link_negotiator_test;

    localparam int CAL   = 3;
    localparam int NVEC  = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       common_req = 1'b0;
    logic [1:0] host_mask = 2'b00;
    logic       los = 1'b0;
    logic       cominit_det = 1'b0;
    logic       comwake_det = 1'b0;
    logic [1:0] align_det = 2'b00;
    logic       comreset_req, calibrate_req, comwake_req;
    logic [1:0] tx_pat;
    logic [0:0] rate_sel;
    logic       link_up;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    drv_link_negotiator #(
        .NUM_GEN (2), .CNT_W (8), .INIT_TMO (8), .CAL_CYCLES (CAL),
        .WAKE_TMO (8), .ALIGN_TMO (10), .ALIGN_TX (2)
    ) uut (
        .clk (clk), .rst_n (rst_n), .port_en (port_en),
        .common_req (common_req), .host_mask (host_mask), .los (los),
        .cominit_det (cominit_det), .comwake_det (comwake_det),
        .align_det (align_det), .comreset_req (comreset_req),
        .calibrate_req (calibrate_req), .comwake_req (comwake_req),
        .tx_pat (tx_pat), .rate_sel (rate_sel), .link_up (link_up),
        .state_o (state_o)
    );

    // Vector: en, common, mask[1:0], cominit, comwake, align[1:0], los |
    //         expected state[2:0], link_up, rate_sel, tx_pat[1:0]
    localparam logic [15:0] VEC [NVEC] = '{
        16'b1_0_00_0_0_00_0_001_0_0_00,
        16'b1_0_00_1_0_00_0_010_0_0_00,
        16'b1_0_00_0_0_00_0_010_0_0_00,
        16'b1_0_00_0_0_00_0_010_0_0_00,
        16'b1_0_00_0_0_00_0_011_0_0_00,
        16'b1_0_00_0_1_00_0_100_0_0_01,
        16'b1_0_00_0_0_00_0_100_0_0_01,
        16'b1_0_00_0_0_10_0_101_0_1_10,
        16'b1_0_00_0_0_00_0_101_0_1_10,
        16'b1_0_00_0_0_00_0_110_1_1_11,
        16'b1_0_00_0_0_00_1_000_0_0_00,
        16'b1_1_01_0_0_00_0_001_0_0_00,
        16'b1_1_01_1_0_00_0_010_0_0_00,
        16'b1_1_01_0_0_00_0_010_0_0_00,
        16'b1_1_01_0_0_00_0_010_0_0_00,
        16'b1_1_01_0_0_00_0_011_0_0_00,
        16'b1_1_01_0_1_00_0_100_0_0_01,
        16'b1_1_01_0_0_10_0_100_0_0_01,
        16'b1_1_01_0_0_01_0_101_0_0_10,
        16'b1_1_01_0_0_00_0_101_0_0_10,
        16'b1_1_01_0_0_00_0_110_1_0_11,
        16'b1_1_01_1_0_00_0_000_0_0_00
    };

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // From RESET with the port enabled, run the handshake up to the filler.
    task automatic go_fill;
        port_en = 1'b1;
        step;
        cominit_det = 1'b1;
        step;
        cominit_det = 1'b0;
        repeat (CAL) step;
        comwake_det = 1'b1;
        step;
        comwake_det = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step;
        chk("R1 reset state", state_o, 0);
        chk("R1 reset link_up", link_up, 0);
        chk("R1 reset tx_pat", tx_pat, 0);
        chk("R1 reset pulses", {comreset_req, calibrate_req, comwake_req}, 0);
        rst_n = 1'b1;
        step;
        chk("R1 disabled stays reset", state_o, 0);

        for (int i = 0; i < NVEC; i++) begin
            port_en     = VEC[i][15];
            common_req  = VEC[i][14];
            host_mask   = VEC[i][13:12];
            cominit_det = VEC[i][11];
            comwake_det = VEC[i][10];
            align_det   = VEC[i][9:8];
            los         = VEC[i][7];
            step;
            chk($sformatf("R5 R6 R8 R9 R10 vector %0d", i),
                {state_o, link_up, rate_sel, tx_pat}, int'(VEC[i][6:0]));
        end
        port_en = 1'b0; common_req = 1'b0; host_mask = 2'b00;
        cominit_det = 1'b0; comwake_det = 1'b0; align_det = 2'b00; los = 1'b0;
        step;

        // R2: one-cycle COMRESET on entry to AWAIT_COMINIT
        port_en = 1'b1;
        step;
        chk("R2 comreset on entry", comreset_req, 1);
        chk("R2 state await cominit", state_o, 1);
        step;
        chk("R2 comreset single cycle", comreset_req, 0);
        // R3: COMINIT timeout after 8 cycles, then reissue
        repeat (6) step;
        chk("R3 still waiting", state_o, 1);
        step;
        chk("R3 timeout to reset", state_o, 0);
        step;
        chk("R3 reissued comreset", comreset_req, 1);
        // R2/R4: calibrate and wake requests, wake timeout
        cominit_det = 1'b1;
        step;
        cominit_det = 1'b0;
        chk("R2 calibrate pulse", calibrate_req, 1);
        step;
        chk("R2 calibrate single cycle", calibrate_req, 0);
        step;
        step;
        chk("R4 calibrate length", state_o, 3);
        chk("R4 comwake pulse", comwake_req, 1);
        repeat (7) step;
        chk("R4 still awaiting wake", state_o, 3);
        step;
        chk("R4 wake timeout", state_o, 0);

        // R7: ALIGN timeout of 10 cycles
        go_fill;
        chk("R5 filler pattern", tx_pat, 1);
        repeat (9) step;
        chk("R7 still filling", state_o, 4);
        step;
        chk("R7 align timeout", state_o, 0);

        // R6: both rate strobes together pick the higher rate
        go_fill;
        align_det = 2'b11;
        step;
        align_det = 2'b00;
        chk("R6 both strobes state", state_o, 5);
        chk("R6 both strobes rate", rate_sel, 1);
        step;
        step;
        chk("R9 ready link_up", link_up, 1);

        // R1: port disable from READY
        port_en = 1'b0;
        step;
        chk("R1 disable state", state_o, 0);
        chk("R1 disable link_up", link_up, 0);
        chk("R1 disable rate", rate_sel, 0);

        // R8: shared speed requested but no host rate set
        common_req = 1'b1;
        host_mask  = 2'b00;
        go_fill;
        align_det = 2'b10;
        step;
        align_det = 2'b00;
        chk("R8 empty mask accepts fast", rate_sel, 1);
        chk("R8 empty mask state", state_o, 5);

        // R8: mask excludes the slow rate
        port_en = 1'b0;
        step;
        host_mask = 2'b10;
        go_fill;
        align_det = 2'b01;
        step;
        chk("R8 slow ignored state", state_o, 4);
        chk("R8 slow ignored rate", rate_sel, 0);
        align_det = 2'b10;
        step;
        align_det = 2'b00;
        chk("R8 fast accepted", rate_sel, 1);
        step;
        step;
        chk("R9 ready state", state_o, 6);
        // R10: COMINIT in READY
        cominit_det = 1'b1;
        step;
        cominit_det = 1'b0;
        chk("R10 cominit drops link", state_o, 0);

        // R1: synchronous reset mid-handshake
        step;
        rst_n = 1'b0;
        step;
        chk("R1 reset mid-run state", state_o, 0);
        chk("R1 reset mid-run tx", tx_pat, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule